// File: doc/BRIEF.md
# Bus-Activity Automatic Power-Down Unit

This block sits between a microcontroller's external bus and the on-chip memories, control registers and programmable logic. It watches the address-latch strobe, and any change of level on it counts as bus activity. A free-running clock drives an idle counter that is cleared by every strobe edge. If the feature is enabled and the strobe stays quiet for a set number of clocks, the unit enters power-down. While powered down it freezes the address and data buses at their last value and forces every downstream select low. Downstream parts then stay quiet even when the external lines keep toggling.

A separate chip-select input can turn off the flash and SRAM selects on its own. It does not freeze the bus and does not touch the control-register select. The strobe and the chip-select input are synchronised into the clock domain with two flops each.

The controller has three states. `APD_IDLE` is the state while the feature is disabled. `APD_RUN` counts idle time. `APD_DOWN` is power-down. The transitions are:
- enable-set: `APD_IDLE` to `APD_RUN`
- enable-clear: `APD_RUN` or `APD_DOWN` to `APD_IDLE`
- timeout: `APD_RUN` to `APD_DOWN`, when the count reaches its limit with no edge present
- wake: `APD_DOWN` to `APD_RUN`, on a strobe edge

Top module: `apd_unit`

## Requirements
- R1: While `apd_en` is low, `pdn` stays low and the idle count is held at zero. When `apd_en` rises, counting starts from zero.
- R2: A change of level on `ale`, rising or falling, passes through a two-flop synchroniser. It clears the idle count at the third rising clock edge after the change.
- R3: `pdn` rises at the TERM-th consecutive clock edge without activity, counted from the last clear or from reset. TERM is 15 by default.
- R4: While `pdn` is high, `addr_out` and `data_out` hold the value their inputs had at the edge where `pdn` rose. Changes on `addr_in` and `data_in` have no effect on them.
- R5: While `pdn` is high, `flash_sel_out`, `sram_sel_out` and `creg_sel_out` are all low, whatever the raw select inputs are. All selects are active high.
- R6: In power-down, a change of level on `ale` drops `pdn` at the third clock edge after the change. At that point the bus passes through again, the selects follow their inputs, and the idle count restarts from zero.
- R7: The asynchronous active-high `rst` forces `pdn` low at once, clears the idle count and puts the controller in `APD_IDLE`.
- R8: Two clock edges after `cs_in` goes low, `flash_sel_out` and `sram_sel_out` are low. The bus outputs, `creg_sel_out` and `pdn` are unaffected by `cs_in`.
- R9: Clearing `apd_en` while in power-down drops `pdn` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running clock for the synchronisers and the idle counter |
| rst | input | 1 | asynchronous reset, active high |
| apd_en | input | 1 | enable for automatic power-down |
| ale | input | 1 | address-latch strobe from the microcontroller (asynchronous) |
| cs_in | input | 1 | chip-select input, active high; low deselects flash and SRAM (asynchronous) |
| addr_in | input | AW (16) | address bus from the microcontroller |
| data_in | input | DW (8) | data bus from the microcontroller |
| flash_sel_in | input | 1 | raw flash select |
| sram_sel_in | input | 1 | raw SRAM select |
| creg_sel_in | input | 1 | raw control-register select |
| addr_out | output | AW (16) | gated address bus |
| data_out | output | DW (8) | gated data bus |
| flash_sel_out | output | 1 | gated flash select |
| sram_sel_out | output | 1 | gated SRAM select |
| creg_sel_out | output | 1 | gated control-register select |
| pdn | output | 1 | power-down flag |

## Verification
A controller stuck in or wrongly placed in `APD_DOWN` shows on the same clock edge as a high `pdn`, frozen bus outputs and all-low selects. An off-by-one in the idle counter moves the rising edge of `pdn` by one clock, so the bench samples `pdn` on both sides of the expected edge. A fault in the synchroniser or the edge detector shifts the wake point or the counter clear away from the third edge after the strobe toggles, and shows within three clocks. A fault on the chip-select path shows as flash or SRAM selects that stay high, or that fall on the wrong edge.

// File: rtl/apd_pkg.sv
package apd_pkg;

    // Controller states
    typedef enum logic [1:0] {
        APD_IDLE = 2'd0,   // feature disabled, count held at zero
        APD_RUN  = 2'd1,   // counting idle clocks
        APD_DOWN = 2'd2    // power-down: bus frozen, selects off
    } apd_state_e;

    // Positions of the two synchronised control inputs
    localparam int SYNC_ALE = 0;
    localparam int SYNC_CS  = 1;
    localparam int SYNC_W   = 2;

endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // One two-flop chain per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                stage1_q[i] <= RST_VAL[i];
                stage2_q[i] <= RST_VAL[i];
            end else begin
                stage1_q[i] <= async_in[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/apd_edge_det.sv
module apd_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic toggle
);

    logic prev_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_in;
    end

    // Rising and falling edges both count as activity
    assign toggle = level_in ^ prev_q;

endmodule

// File: rtl/apd_idle_ctr.sv
module apd_idle_ctr #(
    parameter int TERM = 15,
    localparam int CW  = $clog2(TERM + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] LIMIT = CW'(TERM);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (inc && (count_q != LIMIT)) begin
            count_q <= count_q + CW'(1);
        end
    end

    assign count = count_q;

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= LIMIT); // R3

endmodule

// File: rtl/apd_bus_hold.sv
module apd_bus_hold #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         freeze,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out
);

    logic [W-1:0] hold_q;

    // Tracks the bus while open, keeps the last value while frozen
    always_ff @(posedge clk or posedge rst) begin
        if (rst)          hold_q <= '0;
        else if (!freeze) hold_q <= bus_in;
    end

    assign bus_out = freeze ? hold_q : bus_in;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (freeze && $past(freeze)) |-> $stable(bus_out)); // R4

endmodule

// File: rtl/apd_unit.sv
module apd_unit
    import apd_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int TERM = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          apd_en,
    input  logic          ale,
    input  logic          cs_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          flash_sel_in,
    input  logic          sram_sel_in,
    input  logic          creg_sel_in,
    output logic [AW-1:0] addr_out,
    output logic [DW-1:0] data_out,
    output logic          flash_sel_out,
    output logic          sram_sel_out,
    output logic          creg_sel_out,
    output logic          pdn
);

    localparam int            BW      = AW + DW;
    localparam int            CW      = $clog2(TERM + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(TERM);
    localparam logic [CW-1:0] CNT_PRE = CW'(TERM - 1);

    apd_state_e    state_q;
    apd_state_e    state_d;
    logic [SYNC_W-1:0] raw_ctl;
    logic [SYNC_W-1:0] sync_ctl;
    logic          ale_s;
    logic          cs_s;
    logic          act_edge;
    logic          cnt_clr;
    logic          cnt_inc;
    logic [CW-1:0] idle_cnt;
    logic          freeze;
    logic [BW-1:0] bus_gated;

    // Synchronise strobe and chip select into the clock domain
    always_comb begin
        raw_ctl           = '0;
        raw_ctl[SYNC_ALE] = ale;
        raw_ctl[SYNC_CS]  = cs_in;
    end

    apd_sync #(.W(SYNC_W), .RST_VAL('0)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (raw_ctl),
        .sync_out (sync_ctl)
    );

    assign ale_s = sync_ctl[SYNC_ALE];
    assign cs_s  = sync_ctl[SYNC_CS];

    apd_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (ale_s),
        .toggle   (act_edge)
    );

    // Counter clears on activity or while disabled, and freezes in power-down
    assign cnt_clr = act_edge || !apd_en;
    assign cnt_inc = (state_q != APD_DOWN);

    apd_idle_ctr #(.TERM(TERM)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (idle_cnt)
    );

    // State register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= APD_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            APD_IDLE: begin
                if (apd_en) state_d = APD_RUN;           // enable-set
            end
            APD_RUN: begin
                if (!apd_en)
                    state_d = APD_IDLE;                  // enable-clear
                else if (!act_edge && (idle_cnt == CNT_PRE))
                    state_d = APD_DOWN;                  // timeout
            end
            APD_DOWN: begin
                if (!apd_en)
                    state_d = APD_IDLE;                  // enable-clear
                else if (act_edge)
                    state_d = APD_RUN;                   // wake
            end
            default: state_d = APD_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        freeze        = (state_q == APD_DOWN);
        pdn           = freeze;
        flash_sel_out = flash_sel_in && cs_s && !freeze;
        sram_sel_out  = sram_sel_in  && cs_s && !freeze;
        creg_sel_out  = creg_sel_in  && !freeze;
    end

    apd_bus_hold #(.W(BW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .freeze  (freeze),
        .bus_in  ({addr_in, data_in}),
        .bus_out (bus_gated)
    );

    assign addr_out = bus_gated[BW-1:DW];
    assign data_out = bus_gated[DW-1:0];

    AST_EN_GATES_PDN: assert property (@(posedge clk) disable iff (rst)
        !apd_en |=> !pdn); // R1

    AST_PDN_AT_TERM: assert property (@(posedge clk) disable iff (rst)
        pdn |-> (idle_cnt == CNT_TOP)); // R3

    AST_SEL_OFF: assert property (@(posedge clk) disable iff (rst)
        pdn |-> !(flash_sel_out || sram_sel_out || creg_sel_out)); // R5

    AST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (pdn && act_edge) |=> (!pdn && (idle_cnt == '0))); // R6

    AST_DROP_EN: assert property (@(posedge clk) disable iff (rst)
        (pdn && !apd_en) |=> !pdn); // R9

endmodule

// File: tb/sim_apd_unit.sv
`timescale 1ns/1ps
module sim_apd_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        apd_en, ale, cs_in;
    logic [15:0] addr_in;
    logic [7:0]  data_in;
    logic        flash_sel_in, sram_sel_in, creg_sel_in;
    logic [15:0] addr_out;
    logic [7:0]  data_out;
    logic        flash_sel_out, sram_sel_out, creg_sel_out, pdn;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    apd_unit u0 (
        .clk(clk), .rst(rst), .apd_en(apd_en), .ale(ale), .cs_in(cs_in),
        .addr_in(addr_in), .data_in(data_in),
        .flash_sel_in(flash_sel_in), .sram_sel_in(sram_sel_in), .creg_sel_in(creg_sel_in),
        .addr_out(addr_out), .data_out(data_out),
        .flash_sel_out(flash_sel_out), .sram_sel_out(sram_sel_out),
        .creg_sel_out(creg_sel_out), .pdn(pdn)
    );

    typedef struct packed {
        logic        ale;
        logic        en;
        logic        cs;
        logic [15:0] addr;
        logic [2:0]  sel;      // {flash, sram, creg}
        logic [7:0]  n;        // clock edges to wait
        logic        epdn;
        logic [15:0] eaddr;
        logic [2:0]  esel;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [0:NV-1] = '{
        '{1'b0,1'b1,1'b1,16'h1234,3'b111,8'd14,1'b0,16'h1234,3'b111,4'd3},
        '{1'b0,1'b1,1'b1,16'h1234,3'b111,8'd1, 1'b1,16'h1234,3'b000,4'd3},
        '{1'b0,1'b1,1'b1,16'hABCD,3'b111,8'd1, 1'b1,16'h1234,3'b000,4'd4},
        '{1'b1,1'b1,1'b1,16'hABCD,3'b111,8'd2, 1'b1,16'h1234,3'b000,4'd6},
        '{1'b1,1'b1,1'b1,16'hABCD,3'b111,8'd1, 1'b0,16'hABCD,3'b111,4'd6},
        '{1'b0,1'b1,1'b1,16'h5555,3'b111,8'd2, 1'b0,16'h5555,3'b111,4'd2},
        '{1'b0,1'b1,1'b1,16'h5555,3'b111,8'd1, 1'b0,16'h5555,3'b111,4'd2},
        '{1'b0,1'b1,1'b1,16'h5555,3'b111,8'd14,1'b0,16'h5555,3'b111,4'd2},
        '{1'b0,1'b1,1'b1,16'h5555,3'b111,8'd1, 1'b1,16'h5555,3'b000,4'd5},
        '{1'b0,1'b0,1'b1,16'h5555,3'b111,8'd1, 1'b0,16'h5555,3'b111,4'd9},
        '{1'b0,1'b0,1'b1,16'h5555,3'b111,8'd40,1'b0,16'h5555,3'b111,4'd1},
        '{1'b0,1'b0,1'b0,16'h5555,3'b111,8'd1, 1'b0,16'h5555,3'b111,4'd8},
        '{1'b0,1'b0,1'b0,16'h5555,3'b111,8'd1, 1'b0,16'h5555,3'b001,4'd8},
        '{1'b1,1'b0,1'b0,16'h0F0F,3'b111,8'd3, 1'b0,16'h0F0F,3'b001,4'd8},
        '{1'b1,1'b0,1'b1,16'h0F0F,3'b111,8'd2, 1'b0,16'h0F0F,3'b111,4'd8},
        '{1'b1,1'b1,1'b1,16'h0F0F,3'b111,8'd14,1'b0,16'h0F0F,3'b111,4'd1},
        '{1'b1,1'b1,1'b1,16'h0F0F,3'b111,8'd1, 1'b1,16'h0F0F,3'b000,4'd3}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Wait n rising edges, then move to the following falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; apd_en = 1'b1; ale = 1'b0; cs_in = 1'b1;
        addr_in = 16'h1234; data_in = 8'h5A;
        flash_sel_in = 1'b1; sram_sel_in = 1'b1; creg_sel_in = 1'b1;
        tick(3);
        // Reset state (R7): no power-down, bus passes, chip select not yet synced
        check("R7", "pdn in reset", {31'd0, pdn}, 32'd0);
        check("R7", "addr in reset", {16'd0, addr_out}, 32'h1234);
        check("R7", "selects in reset",
              {29'd0, flash_sel_out, sram_sel_out, creg_sel_out}, 32'b001);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            ale = TBL[i].ale; apd_en = TBL[i].en; cs_in = TBL[i].cs;
            addr_in = TBL[i].addr;
            {flash_sel_in, sram_sel_in, creg_sel_in} = TBL[i].sel;
            tick(int'(TBL[i].n));
            check(req_name(TBL[i].req), $sformatf("pdn step %0d", i),
                  {31'd0, pdn}, {31'd0, TBL[i].epdn});
            check(req_name(TBL[i].req), $sformatf("addr step %0d", i),
                  {16'd0, addr_out}, {16'd0, TBL[i].eaddr});
            check(req_name(TBL[i].req), $sformatf("sel step %0d", i),
                  {29'd0, flash_sel_out, sram_sel_out, creg_sel_out},
                  {29'd0, TBL[i].esel});
        end

        // R4: data bus frozen at last value while powered down
        data_in = 8'hC3;
        tick(1);
        check("R4", "data frozen", {24'd0, data_out}, 32'h5A);
        check("R5", "raw selects ignored", {29'd0, flash_sel_out, sram_sel_out, creg_sel_out}, 32'd0);

        // R7: reset mid power-down drops pdn at once
        ale = 1'b0;
        rst = 1'b1;
        #1;
        check("R7", "pdn on async reset", {31'd0, pdn}, 32'd0);
        check("R7", "data passes after reset", {24'd0, data_out}, 32'hC3);
        tick(1);
        rst = 1'b0;
        // R3: count restarts from zero after reset
        tick(14);
        check("R3", "pdn one short of limit", {31'd0, pdn}, 32'd0);
        tick(1);
        check("R3", "pdn at limit", {31'd0, pdn}, 32'd1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule